// File: doc/BRIEF.md
# Interleaved ROM/DRAM Memory Controller

This block drives a single external memory bus that is shared by a CPU port and a synthesizer port. Time on the bus is cut into access slots of exactly three master clocks, and the slots are handed out strictly in turn: CPU, synthesizer, CPU, and so on. A slot indicator output tells the outside world which requester owns the current slot. Each requester holds its request level until it receives a one-clock acknowledge; the request is sampled only at the start of that requester's own slot.

Three active-low device strobes are produced. Device 0 is always a 16-bit ROM. Devices 1 and 2 share one type strap: static memory when it is low, DRAM when it is high. A 2-bit density strap sets how a DRAM word address is split into row and column on the low 12 address lines. Static devices see the whole 23-bit address for the whole slot. Whenever DRAM is configured, every static access, and every slot that has no request, also runs a CAS-before-RAS refresh on both DRAM banks, so no separate refresh scheduling exists.

The slot sequencer is a four-state machine: `PH_RESET` (held in reset, all strobes idle) moves to `PH_ADDR` (slot cycle 0: address out, RAS for DRAM, request and straps captured), then `PH_STROBE` (cycle 1: CAS or chip select, byte write enables), then `PH_DATA` (cycle 2: read data sampled at its end, refresh RAS), and from `PH_DATA` back to `PH_ADDR` with the owner flipped.

Top module: `mem_interleave_ctrl`

## Requirements
- R1: Slots last exactly three clocks. The first slot after reset belongs to the CPU, and `bus_owner` (0 = CPU, 1 = synthesizer) flips at the start of every later slot and is stable within a slot.
- R2: While reset is held, `ras_n`, all `cas_n` bits and both `we_n` bits are high, and `bus_owner` and both acknowledges are low.
- R3: A static access drives the full 23-bit address on `mem_addr` for all three slot cycles; the selected device strobe is high in cycle 0 and low in cycles 1 and 2.
- R4: A DRAM access drives the row in cycle 0 and the column in cycles 1 and 2 on `mem_addr[11:0]` (upper bits zero); `ras_n` is low in all three cycles and only the addressed `cas_n` bit goes low, in cycles 1 and 2.
- R5: With density code s (00 = 64K, 01 = 256K, 10 = 1M, 11 = 4M) and K = 8 + s, the device offset is `addr[20:0]`; the column is offset bits K-1..0 and the row is offset bits 2K-1..K, missing bits reading as zero.
- R6: With the DRAM strap high, a static access also pulls `cas_n[2]` and `cas_n[1]` low in cycles 1 and 2 and `ras_n` low in cycle 2 only (CAS before RAS).
- R7: A slot whose owner has no request drives `mem_addr` to zero and no write enables; it runs the refresh pattern of R6 on `cas_n[2:1]` and `ras_n` when the DRAM strap is high, and leaves every strobe high when it is low.
- R8: Address bits 22:21 pick the device: 00 is device 0 (always static ROM), 01 is device 1, 10 and 11 are device 2.
- R9: On a CPU write, `we_n[1]` and `we_n[0]` are the inverted byte enables `cpu_be[1]` and `cpu_be[0]` in cycles 1 and 2 and high in cycle 0; `mem_wdata_oe` is high and `mem_wdata` carries the write data for the whole slot. Reads and synthesizer slots keep both write enables high and `mem_wdata_oe` low.
- R10: The acknowledge of a served request is high for exactly the first clock of the next slot; for a read, the matching `*_rdata` then holds the value of `mem_rdata` sampled at the end of cycle 2.
- R11: A request is seen only at the start of its own requester's slot; a synthesizer request raised during a CPU slot with no CPU request leaves that slot empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dram_strap | input | 1 | Type of devices 1 and 2: 0 static, 1 DRAM |
| size_strap | input | 2 | DRAM density code |
| cpu_req | input | 1 | CPU request level |
| cpu_we | input | 1 | CPU request is a write |
| cpu_be | input | 2 | CPU byte enables, bit 1 upper byte |
| cpu_addr | input | 23 | CPU word address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_ack | output | 1 | CPU access done |
| cpu_rdata | output | 16 | CPU read data |
| syn_req | input | 1 | Synthesizer read request level |
| syn_addr | input | 23 | Synthesizer word address |
| syn_ack | output | 1 | Synthesizer access done |
| syn_rdata | output | 16 | Synthesizer read data |
| mem_addr | output | 23 | External memory address |
| mem_wdata | output | 16 | External write data |
| mem_wdata_oe | output | 1 | Write data drive enable |
| mem_rdata | input | 16 | External read data |
| ras_n | output | 1 | Row strobe to all DRAM |
| cas_n | output | 3 | Per-device column strobe / chip select |
| we_n | output | 2 | Byte write enables, bit 1 upper byte |
| bus_owner | output | 1 | Slot owner: 0 CPU, 1 synthesizer |

## Verification
Inputs for a slot are applied on the falling edge inside cycle 2 of the previous slot, so they are captured by the edge that opens the slot; strobes, address and write enables are then due in slot cycles 0, 1 and 2, the three clocks after that edge, and the acknowledge with read data is due in cycle 0 of the following slot. The monitor keeps its own cycle-in-slot counter started from the reset release, pops the expected slot record in cycle 0 and compares every output on each falling edge, so each result is sampled half a clock after the edge that produced it. Read data for the slot is presented by the monitor in cycle 0 and held until the next slot begins, covering the sampling edge at the end of cycle 2.

// File: rtl/mem_ilv_pkg.sv
package mem_ilv_pkg;

    typedef enum logic [1:0] {
        PH_RESET  = 2'd0,
        PH_ADDR   = 2'd1,
        PH_STROBE = 2'd2,
        PH_DATA   = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        AK_IDLE    = 2'd0,
        AK_STATIC  = 2'd1,
        AK_DRAM    = 2'd2,
        AK_REFRESH = 2'd3
    } acc_kind_e;

    typedef enum logic {
        OWN_CPU = 1'b0,
        OWN_SYN = 1'b1
    } owner_e;

    // Device field of the address: 00 ROM, 01 device 1, 1x device 2
    function automatic logic [1:0] dev_decode(input logic [1:0] field);
        logic [1:0] dev;
        if (field == 2'b00)      dev = 2'd0;
        else if (field == 2'b01) dev = 2'd1;
        else                     dev = 2'd2;
        return dev;
    endfunction

endpackage

// File: rtl/mem_ilv_slot_fsm.sv
module mem_ilv_slot_fsm
    import mem_ilv_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int DATA_W = 16,
    parameter int BE_W   = 2,
    parameter int SIZE_W = 2,
    parameter int DEV_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [BE_W-1:0]   cpu_be,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              syn_req,
    input  logic [ADDR_W-1:0] syn_addr,
    input  logic              dram_strap,
    input  logic [SIZE_W-1:0] size_strap,
    output phase_e            phase,
    output owner_e            owner,
    output logic              cur_valid,
    output logic              cur_we,
    output logic [BE_W-1:0]   cur_be,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              cur_dram,
    output logic [SIZE_W-1:0] cur_size,
    output logic [DEV_W-1:0]  cur_dev,
    output acc_kind_e         cur_kind
);

    phase_e phase_q, phase_d;
    owner_e owner_q, owner_d;
    logic   slot_start;

    // next-state logic
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_RESET:  phase_d = PH_ADDR;
            PH_ADDR:   phase_d = PH_STROBE;
            PH_STROBE: phase_d = PH_DATA;
            PH_DATA:   phase_d = PH_ADDR;
        endcase
    end

    assign slot_start = (phase_q == PH_RESET) || (phase_q == PH_DATA);
    assign owner_d    = (phase_q == PH_RESET) ? OWN_CPU : owner_e'(~owner_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_RESET;
            owner_q <= OWN_CPU;
        end else begin
            phase_q <= phase_d;
            if (slot_start) owner_q <= owner_d;
        end
    end

    // request capture at the opening edge of each slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_valid <= 1'b0;
            cur_we    <= 1'b0;
            cur_be    <= '0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_dram  <= 1'b0;
            cur_size  <= '0;
        end else if (slot_start) begin
            cur_dram <= dram_strap;
            cur_size <= size_strap;
            if (owner_d == OWN_CPU) begin
                cur_valid <= cpu_req;
                cur_we    <= cpu_we;
                cur_be    <= cpu_be;
                cur_addr  <= cpu_addr;
                cur_wdata <= cpu_wdata;
            end else begin
                cur_valid <= syn_req;
                cur_we    <= 1'b0;
                cur_be    <= '0;
                cur_addr  <= syn_addr;
                cur_wdata <= '0;
            end
        end
    end

    // access kind of the current slot
    always_comb begin
        cur_dev = DEV_W'(dev_decode(cur_addr[ADDR_W-1 -: 2]));
        if (cur_valid) begin
            cur_kind = (cur_dev != '0 && cur_dram) ? AK_DRAM : AK_STATIC;
        end else begin
            cur_kind = cur_dram ? AK_REFRESH : AK_IDLE;
        end
    end

    assign phase = phase_q;
    assign owner = owner_q;

    a_r1_owner_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STROBE || phase_q == PH_DATA) |-> $stable(owner_q));

    a_r1_owner_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ADDR && $past(phase_q) == PH_DATA) |-> (owner_q != $past(owner_q)));

    a_r1_first_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ADDR && $past(phase_q) == PH_RESET) |-> (owner_q == OWN_CPU));

endmodule

// File: rtl/mem_ilv_addr_mux.sv
module mem_ilv_addr_mux
    import mem_ilv_pkg::*;
#(
    parameter int ADDR_W     = 23,
    parameter int DEV_SEL_W  = 2,
    parameter int DRAM_AW    = 12,
    parameter int SIZE_W     = 2,
    parameter int BASE_COL_W = 8
) (
    input  phase_e            phase,
    input  acc_kind_e         kind,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [SIZE_W-1:0] cur_size,
    output logic [ADDR_W-1:0] mem_addr
);

    localparam int NUM_SIZES = 1 << SIZE_W;
    localparam int OFF_W     = ADDR_W - DEV_SEL_W;

    logic [OFF_W-1:0]   off;
    logic [DRAM_AW-1:0] row_opt [NUM_SIZES];
    logic [DRAM_AW-1:0] col_opt [NUM_SIZES];

    assign off = cur_addr[OFF_W-1:0];

    // one row/column split per density code
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_density
        localparam int SPLIT = BASE_COL_W + g;
        logic [OFF_W-1:0] mask;
        logic [OFF_W-1:0] upper;
        assign mask       = (OFF_W'(1) << SPLIT) - OFF_W'(1);
        assign upper      = off >> SPLIT;
        assign col_opt[g] = DRAM_AW'(off & mask);
        assign row_opt[g] = DRAM_AW'(upper & mask);
    end

    always_comb begin
        mem_addr = '0;
        unique case (kind)
            AK_STATIC:  mem_addr = cur_addr;
            AK_DRAM:    mem_addr = (phase == PH_ADDR) ? ADDR_W'(row_opt[cur_size])
                                                      : ADDR_W'(col_opt[cur_size]);
            AK_IDLE:    mem_addr = '0;
            AK_REFRESH: mem_addr = '0;
        endcase
    end

endmodule

// File: rtl/mem_ilv_strobe_gen.sv
module mem_ilv_strobe_gen
    import mem_ilv_pkg::*;
#(
    parameter int NUM_DEV = 3,
    parameter int DEV_W   = 2,
    parameter int BE_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  phase_e             phase,
    input  acc_kind_e          kind,
    input  logic [DEV_W-1:0]   cur_dev,
    input  logic               cur_dram,
    input  logic               cur_valid,
    input  logic               cur_we,
    input  logic [BE_W-1:0]    cur_be,
    output logic               ras_n,
    output logic [NUM_DEV-1:0] cas_n,
    output logic [BE_W-1:0]    we_n,
    output logic               wdata_oe
);

    logic in_slot, late, cbr_on, access;

    assign in_slot = (phase != PH_RESET);
    assign late    = (phase == PH_STROBE) || (phase == PH_DATA);
    assign access  = (kind == AK_STATIC) || (kind == AK_DRAM);
    assign cbr_on  = (kind == AK_REFRESH) || (kind == AK_STATIC && cur_dram);

    // row strobe per access kind
    always_comb begin
        ras_n = 1'b1;
        unique case (kind)
            AK_DRAM:    ras_n = !in_slot;
            AK_STATIC:  ras_n = !(cur_dram && phase == PH_DATA);
            AK_REFRESH: ras_n = !(phase == PH_DATA);
            AK_IDLE:    ras_n = 1'b1;
        endcase
    end

    // device strobes: selected device, plus refresh on the DRAM banks
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        logic sel, refr;
        assign sel      = access && (cur_dev == DEV_W'(g));
        assign refr     = (g != 0) && cbr_on;
        assign cas_n[g] = !(late && (sel || refr));
    end

    assign we_n     = (cur_valid && cur_we && late) ? ~cur_be : '1;
    assign wdata_oe = in_slot && cur_valid && cur_we;

    a_r6_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && kind != AK_DRAM) |-> ($past(cas_n[NUM_DEV-1:1]) == '0));

    a_r4_one_dram_cas: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == AK_DRAM) |-> ($countones(~cas_n) <= 1));

    a_r3_cs_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n[0]) |-> (phase == PH_STROBE));

    a_r9_we_inside_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (we_n != '1) |-> (wdata_oe && $past(wdata_oe)));

endmodule

// File: rtl/mem_ilv_return.sv
module mem_ilv_return
    import mem_ilv_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  owner_e            owner,
    input  logic              cur_valid,
    input  logic              cur_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              syn_ack,
    output logic [DATA_W-1:0] syn_rdata
);

    logic done;
    assign done = (phase == PH_DATA) && cur_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_ack   <= 1'b0;
            syn_ack   <= 1'b0;
            cpu_rdata <= '0;
            syn_rdata <= '0;
        end else begin
            cpu_ack <= done && (owner == OWN_CPU);
            syn_ack <= done && (owner == OWN_SYN);
            if (done && !cur_we) begin
                if (owner == OWN_CPU) cpu_rdata <= mem_rdata;
                else                  syn_rdata <= mem_rdata;
            end
        end
    end

    a_r10_ack_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_ack, syn_ack}));

    a_r10_ack_slot_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack || syn_ack) |-> (phase == PH_ADDR && $past(phase) == PH_DATA));

endmodule

// File: rtl/mem_interleave_ctrl.sv
module mem_interleave_ctrl
    import mem_ilv_pkg::*;
#(
    parameter int ADDR_W     = 23,
    parameter int DATA_W     = 16,
    parameter int NUM_DEV    = 3,
    parameter int DRAM_AW    = 12,
    parameter int SIZE_W     = 2,
    parameter int BASE_COL_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dram_strap,
    input  logic [SIZE_W-1:0]   size_strap,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [DATA_W/8-1:0] cpu_be,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic                cpu_ack,
    output logic [DATA_W-1:0]   cpu_rdata,
    input  logic                syn_req,
    input  logic [ADDR_W-1:0]   syn_addr,
    output logic                syn_ack,
    output logic [DATA_W-1:0]   syn_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                mem_wdata_oe,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                ras_n,
    output logic [NUM_DEV-1:0]  cas_n,
    output logic [DATA_W/8-1:0] we_n,
    output logic                bus_owner
);

    localparam int BE_W      = DATA_W / 8;
    localparam int DEV_W     = $clog2(NUM_DEV);
    localparam int DEV_SEL_W = 2;

    phase_e            phase;
    owner_e            owner;
    acc_kind_e         cur_kind;
    logic              cur_valid, cur_we, cur_dram;
    logic [BE_W-1:0]   cur_be;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic [SIZE_W-1:0] cur_size;
    logic [DEV_W-1:0]  cur_dev;

    mem_ilv_slot_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .SIZE_W(SIZE_W), .DEV_W(DEV_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_be(cpu_be),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .syn_req(syn_req), .syn_addr(syn_addr),
        .dram_strap(dram_strap), .size_strap(size_strap),
        .phase(phase), .owner(owner),
        .cur_valid(cur_valid), .cur_we(cur_we), .cur_be(cur_be),
        .cur_addr(cur_addr), .cur_wdata(cur_wdata),
        .cur_dram(cur_dram), .cur_size(cur_size),
        .cur_dev(cur_dev), .cur_kind(cur_kind)
    );

    mem_ilv_addr_mux #(
        .ADDR_W(ADDR_W), .DEV_SEL_W(DEV_SEL_W), .DRAM_AW(DRAM_AW),
        .SIZE_W(SIZE_W), .BASE_COL_W(BASE_COL_W)
    ) u_amux (
        .phase(phase), .kind(cur_kind), .cur_addr(cur_addr),
        .cur_size(cur_size), .mem_addr(mem_addr)
    );

    mem_ilv_strobe_gen #(
        .NUM_DEV(NUM_DEV), .DEV_W(DEV_W), .BE_W(BE_W)
    ) u_strb (
        .clk(clk), .rst_n(rst_n), .phase(phase), .kind(cur_kind),
        .cur_dev(cur_dev), .cur_dram(cur_dram), .cur_valid(cur_valid),
        .cur_we(cur_we), .cur_be(cur_be),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .wdata_oe(mem_wdata_oe)
    );

    mem_ilv_return #(
        .DATA_W(DATA_W)
    ) u_ret (
        .clk(clk), .rst_n(rst_n), .phase(phase), .owner(owner),
        .cur_valid(cur_valid), .cur_we(cur_we), .mem_rdata(mem_rdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .syn_ack(syn_ack), .syn_rdata(syn_rdata)
    );

    assign mem_wdata = cur_wdata;
    assign bus_owner = (owner == OWN_SYN);

endmodule

// File: tb/mem_interleave_ctrl_tb.sv
module mem_interleave_ctrl_tb;

    typedef struct {
        bit        owner;
        bit        valid;
        bit        we;
        bit [1:0]  be;
        bit [22:0] addr;
        bit [15:0] wdata;
        bit [15:0] rdata;
        bit        dram;
        bit [1:0]  size;
        string     tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dram_strap = 1'b0;
    logic [1:0]  size_strap = '0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [1:0]  cpu_be = '0;
    logic [22:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        syn_req = 1'b0;
    logic [22:0] syn_addr = '0;
    logic [15:0] mem_rdata = '0;
    logic        cpu_ack, syn_ack, mem_wdata_oe, ras_n, bus_owner;
    logic [15:0] cpu_rdata, syn_rdata, mem_wdata;
    logic [22:0] mem_addr;
    logic [2:0]  cas_n;
    logic [1:0]  we_n;

    int    n_checks = 0;
    int    n_fail = 0;
    int    slot_idx = 0;
    bit    finished = 0;
    item_t exp_q[$];

    always #10 clk = ~clk;

    mem_interleave_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .dram_strap(dram_strap), .size_strap(size_strap),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_be(cpu_be), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .syn_req(syn_req), .syn_addr(syn_addr), .syn_ack(syn_ack), .syn_rdata(syn_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
        .mem_rdata(mem_rdata), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .bus_owner(bus_owner)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // expected model from the requirements
    function automatic int dev_of(input bit [22:0] a);
        if (a[22:21] == 2'b00) return 0;
        if (a[22:21] == 2'b01) return 1;
        return 2;
    endfunction

    // 0 idle, 1 static, 2 dram, 3 refresh-only
    function automatic int kind_of(input item_t it);
        if (it.valid) return (dev_of(it.addr) != 0 && it.dram) ? 2 : 1;
        return it.dram ? 3 : 0;
    endfunction

    function automatic bit [22:0] dram_line(input item_t it, input bit row);
        int        k = 8 + int'(it.size);
        bit [22:0] off = {2'b00, it.addr[20:0]};
        bit [22:0] m = (23'd1 << k) - 23'd1;
        return row ? ((off >> k) & m) : (off & m);
    endfunction

    task automatic check_cycle(input item_t it, input int ph);
        int        kd = kind_of(it);
        bit        e_ras = 1'b1;
        bit [2:0]  e_cas = 3'b111;
        bit [22:0] e_addr = '0;
        bit [1:0]  e_we = 2'b11;
        bit        cbr = (kd == 3) || (kd == 1 && it.dram);
        if (kd == 2) e_ras = 1'b0;
        if (cbr && ph == 2) e_ras = 1'b0;
        if (ph >= 1) begin
            if (kd == 1 || kd == 2) e_cas[dev_of(it.addr)] = 1'b0;
            if (cbr) e_cas[2:1] = 2'b00;
        end
        if (kd == 1) e_addr = it.addr;
        if (kd == 2) e_addr = dram_line(it, ph == 0);
        if (it.valid && it.we && ph >= 1) e_we = ~it.be;
        chk("R1", "bus_owner", 32'(bus_owner), 32'(it.owner));
        chk(it.tag, "ras_n", 32'(ras_n), 32'(e_ras));
        chk(it.tag, "cas_n", 32'(cas_n), 32'(e_cas));
        chk(it.tag, "mem_addr", 32'(mem_addr), 32'(e_addr));
        chk("R9", "we_n", 32'(we_n), 32'(e_we));
        chk("R9", "mem_wdata_oe", 32'(mem_wdata_oe), 32'(it.valid && it.we));
        if (it.valid && it.we) chk("R9", "mem_wdata", 32'(mem_wdata), 32'(it.wdata));
    endtask

    // monitor: own slot-phase counter, pops one record per slot
    initial begin
        int    ph = 2;
        bit    have_cur = 0, have_prev = 0;
        item_t cur, prev;
        wait (rst_n === 1'b1);
        forever begin
            @(posedge clk);
            ph = (ph + 1) % 3;
            @(negedge clk);
            if (ph == 0) begin
                have_prev = have_cur;
                prev = cur;
                have_cur = (exp_q.size() != 0);
                if (have_cur) begin
                    cur = exp_q.pop_front();
                    mem_rdata = cur.rdata;
                end
                if (have_prev) begin
                    chk("R10", "cpu_ack", 32'(cpu_ack), 32'(prev.valid && !prev.owner));
                    chk("R10", "syn_ack", 32'(syn_ack), 32'(prev.valid && prev.owner));
                    if (prev.valid && !prev.we) begin
                        if (!prev.owner) chk("R10", "cpu_rdata", 32'(cpu_rdata), 32'(prev.rdata));
                        else             chk("R10", "syn_rdata", 32'(syn_rdata), 32'(prev.rdata));
                    end
                end
            end else if (have_cur) begin
                chk("R10", "ack outside slot start", 32'({cpu_ack, syn_ack}), 32'd0);
            end
            if (have_cur) check_cycle(cur, ph);
        end
    end

    // driver: applies one slot's stimulus in cycle 2 of the previous slot
    task automatic do_slot(input bit valid, input bit we, input bit [1:0] be,
                           input bit [22:0] addr, input bit [15:0] wdata,
                           input bit [15:0] rdata, input bit dram, input bit [1:0] size,
                           input bit other_req, input string tag);
        item_t it;
        it.owner = slot_idx[0];
        it.valid = valid;
        it.we = it.owner ? 1'b0 : we;
        it.be = be;
        it.addr = addr;
        it.wdata = wdata;
        it.rdata = rdata;
        it.dram = dram;
        it.size = size;
        it.tag = tag;
        dram_strap = dram;
        size_strap = size;
        if (!it.owner) begin
            cpu_req = valid; cpu_we = we; cpu_be = be; cpu_addr = addr; cpu_wdata = wdata;
            syn_req = other_req; syn_addr = 23'h2A_5A5A;
        end else begin
            syn_req = valid; syn_addr = addr;
            cpu_req = other_req; cpu_we = 1'b1; cpu_be = 2'b11; cpu_addr = 23'h00_0055;
        end
        exp_q.push_back(it);
        slot_idx++;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        chk("R2", "ras_n", 32'(ras_n), 32'd1);
        chk("R2", "cas_n", 32'(cas_n), 32'h7);
        chk("R2", "we_n", 32'(we_n), 32'h3);
        chk("R2", "bus_owner", 32'(bus_owner), 32'd0);
        chk("R2", "acks", 32'({cpu_ack, syn_ack}), 32'd0);
        rst_n = 1'b1;
        do_slot(1, 0, 2'b00, 23'h01_2345, 16'h0, 16'hA1B2, 0, 2'd0, 0, "R3");
        do_slot(1, 0, 2'b00, 23'h23_4567, 16'h0, 16'h1357, 0, 2'd0, 0, "R8");
        do_slot(1, 1, 2'b10, 23'h4A_BCDE, 16'hBEEF, 16'h0, 0, 2'd0, 0, "R8");
        do_slot(0, 0, 2'b00, 23'h00_0000, 16'h0, 16'h0, 0, 2'd0, 0, "R7");
        do_slot(0, 0, 2'b00, 23'h00_0000, 16'h0, 16'h0, 1, 2'd0, 0, "R7");
        do_slot(1, 0, 2'b00, 23'h07_1234, 16'h0, 16'hC0DE, 1, 2'd3, 0, "R6");
        do_slot(1, 1, 2'b01, 23'h00_4321, 16'h5AA5, 16'h0, 1, 2'd1, 0, "R6");
        do_slot(1, 0, 2'b00, 23'h20_A5C3, 16'h0, 16'h2468, 1, 2'd0, 0, "R5");
        do_slot(1, 0, 2'b00, 23'h5F_EDCB, 16'h0, 16'h9BDF, 1, 2'd3, 0, "R4");
        do_slot(1, 1, 2'b01, 23'h3C_3C3C, 16'h7E81, 16'h0, 1, 2'd1, 0, "R5");
        do_slot(1, 0, 2'b00, 23'h31_F0F0, 16'h0, 16'h4455, 1, 2'd2, 0, "R5");
        do_slot(0, 0, 2'b00, 23'h00_0000, 16'h0, 16'h0, 1, 2'd0, 1, "R11");
        do_slot(1, 0, 2'b00, 23'h6A_1111, 16'h0, 16'h6677, 0, 2'd0, 0, "R11");
        do_slot(0, 0, 2'b00, 23'h00_0000, 16'h0, 16'h0, 0, 2'd0, 1, "R11");
        do_slot(1, 0, 2'b00, 23'h55_0F0F, 16'h0, 16'h8899, 0, 2'd0, 0, "R3");
        do_slot(1, 1, 2'b11, 23'h2F_FFFF, 16'hFFFF, 16'h0, 0, 2'd0, 0, "R9");
        for (int i = 0; i < 8; i++) begin
            do_slot(1, i[0], 2'(i + 1), 23'h20_0000 + 23'(i * 23'h1_2345),
                    16'(16'h1111 * i), 16'(16'h0F0F ^ i), 1, 2'(i), 0, "R5");
        end
        do_slot(0, 0, 2'b00, 23'h00_0000, 16'h0, 16'h0, 0, 2'd0, 0, "R7");
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule